// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between a group of processor input pins, already brought into the core clock domain, and the core's exception logic. Pin activity reaches it as events: a valid strobe, a pin index and the new level. The block keeps the last level it saw on every pin. An event that repeats the stored level is dropped. An event that changes a level is decoded according to the sense configured for that pin: active-high level, active-low level, or falling edge.

A decoded pin drives one of three things. It can set or clear a bit of the pending-interrupt vector, hold or release the core-stop output, or fire a one-cycle core-reset request. An aggregate request line is high while any pending bit is set. The core clears pending bits by presenting a mask on the acknowledge input.

Pin sense, destination and pending-bit position are parameters. Their defaults give six pins: external interrupt, management interrupt, machine check, check-stop, hard reset and soft reset.

Top module: `pin_conditioner`

## Requirements
- R1: An event on a defined pin whose level equals the stored level for that pin changes no output and no stored level. An event with a differing level updates the stored level, which is visible on `pin_level` (bit n = pin n) in the cycle after the event.
- R2: Pin 0 (external interrupt) and pin 1 (management interrupt) are active high. `pend_vec` bit 0 and bit 1 respectively become 1 when the pin rises and 0 when it falls, visible in the cycle after the event.
- R3: Pin 2 (machine check) is falling-edge sensitive. A 1-to-0 change sets `pend_vec` bit 2. A 0-to-1 change leaves the pending vector unchanged.
- R4: Pin 3 (check-stop) is active low. A change to 0 sets `core_stop` to 1, and a change to 1 sets it to 0, in the cycle after the event. Otherwise `core_stop` holds its value.
- R5: Pin 4 (hard reset) is active low. A change to 0 raises `core_reset_req` for exactly one cycle, the cycle after the event. A change to 1 produces no request.
- R6: Pin 5 (soft reset) is active high and drives `pend_vec` bit 3, which follows the pin level in the same way as R2.
- R7: `irq_req` is 1 whenever any bit of `pend_vec` is 1, and 0 only when the whole vector is 0.
- R8: An event whose index is 6 or 7 (not a defined pin) changes no output and no stored level.
- R9: Each 1 in `ack_mask` clears the matching `pend_vec` bit in the cycle after it is sampled. When a pin event sets a bit in the same cycle that `ack_mask` clears it, the bit ends up set.
- R10: While `rst_n` is low at a clock edge, `pin_level` becomes 6'b011000 (active-low pins 3 and 4 at 1, the rest at 0), `pend_vec` becomes 0, `core_stop` 0 and `core_reset_req` 0. An event that repeats an idle level right after reset produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_evt_vld | input | 1 | A pin event is present this cycle |
| pin_evt_idx | input | 3 | Index of the pin the event refers to |
| pin_evt_lvl | input | 1 | New level of that pin |
| ack_mask | input | 8 | Pending bits to clear |
| pend_vec | output | 8 | Pending-interrupt vector |
| irq_req | output | 1 | Any pending bit set |
| core_stop | output | 1 | Hold the core stopped |
| core_reset_req | output | 1 | One-cycle core reset request |
| pin_level | output | 6 | Stored last level of every pin |

## Verification
The hardest situation to reach is a pin event that sets a pending bit in the same cycle as an acknowledge that clears that bit. Reaching it needs a level pin that is already high with its bit acknowledged away. The stimulus first lowers that pin and then raises it again while presenting the acknowledge. A second case pairs a machine-check falling edge with an all-ones mask. The vector table also walks each pin through duplicate levels, rising and falling changes and out-of-range indexes. A reset in mid-run, followed by events that repeat the idle levels, shows that no spurious stop or reset follows reset.

// File: rtl/pinc_pkg.sv
package pinc_pkg;

   // Sense of a pin: level active high, level active low, falling edge.
   typedef enum logic [1:0] {
      SENSE_HIGH = 2'd0,
      SENSE_LOW  = 2'd1,
      SENSE_FALL = 2'd2
   } sense_e;

   // What a pin drives once decoded.
   typedef enum logic [1:0] {
      DEST_PEND  = 2'd0,
      DEST_STOP  = 2'd1,
      DEST_RESET = 2'd2
   } dest_e;

   localparam int MAX_PINS = 32;
   localparam int PBIT_FW  = 8;   // field width of a pending-bit index

   // Idle level pattern implied by a sense table: active-low pins rest at 1.
   function automatic logic [MAX_PINS-1:0] idle_of(input logic [2*MAX_PINS-1:0] sense,
                                                    input int n);
      logic [MAX_PINS-1:0] r;
      r = '0;
      for (int i = 0; i < MAX_PINS; i++) begin
         if (i < n) r[i] = (sense[2*i +: 2] == SENSE_LOW);
      end
      return r;
   endfunction

endpackage

// File: rtl/pinc_state.sv
module pinc_state #(
   parameter int                  NUM_PINS = 6,
   parameter int                  IDX_W    = 3,
   parameter logic [NUM_PINS-1:0] IDLE_LVL = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_vld,
   input  logic [IDX_W-1:0]    evt_idx,
   input  logic                evt_lvl,
   output logic [NUM_PINS-1:0] lvl_q,
   output logic [NUM_PINS-1:0] chg
);

   localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_PINS);

   if (IDX_W < $clog2(NUM_PINS + 1)) begin : g_bad_idx
      $error("pinc_state: IDX_W too narrow for NUM_PINS");
   end

   // One change strobe per pin; an index outside the pin range matches none.
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_chg
      assign chg[i] = evt_vld && (evt_idx == IDX_W'(i)) && (evt_lvl != lvl_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= IDLE_LVL;
      end else begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (chg[i]) lvl_q[i] <= evt_lvl;
         end
      end
   end

   AST_IDLE_KEEPS_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_vld |=> $stable(lvl_q)); // R1

   AST_REPEAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld && (evt_idx < IDX_LIMIT) && (evt_lvl == lvl_q[evt_idx])) |=> $stable(lvl_q)); // R1

   AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld && (evt_idx >= IDX_LIMIT)) |=> $stable(lvl_q)); // R8

endmodule

// File: rtl/pinc_decode.sv
module pinc_decode
   import pinc_pkg::*;
#(
   parameter int                    NUM_PINS  = 6,
   parameter int                    PEND_W    = 8,
   parameter logic [2*NUM_PINS-1:0] PIN_SENSE = '0,
   parameter logic [2*NUM_PINS-1:0] PIN_DEST  = '0,
   parameter logic [PBIT_FW*NUM_PINS-1:0] PIN_PBIT = '0
) (
   input  logic [NUM_PINS-1:0] chg,
   input  logic                new_lvl,
   output logic [PEND_W-1:0]   pend_set,
   output logic [PEND_W-1:0]   pend_clr,
   output logic                stop_set,
   output logic                stop_clr,
   output logic                rst_fire
);

   logic [NUM_PINS-1:0] act;
   logic [NUM_PINS-1:0] deact;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam logic [1:0] SNS = PIN_SENSE[2*i +: 2];
      localparam logic [1:0] DST = PIN_DEST[2*i +: 2];
      localparam int         PB  = int'(PIN_PBIT[PBIT_FW*i +: PBIT_FW]);

      if (SNS == 2'd3) begin : g_bad_sense
         $error("pinc_decode: undefined sense code");
      end
      if (DST == 2'd3) begin : g_bad_dest
         $error("pinc_decode: undefined destination code");
      end
      if (DST == DEST_PEND && PB >= PEND_W) begin : g_bad_pbit
         $error("pinc_decode: pending bit outside the vector");
      end

      if (SNS == SENSE_FALL) begin : g_edge
         // Only a 1-to-0 change counts; a rise is dropped.
         assign act[i]   = chg[i] && !new_lvl;
         assign deact[i] = 1'b0;
      end else begin : g_level
         localparam logic ACT_LVL = (SNS == SENSE_LOW) ? 1'b0 : 1'b1;
         assign act[i]   = chg[i] && (new_lvl == ACT_LVL);
         assign deact[i] = chg[i] && (new_lvl != ACT_LVL);
      end
   end

   always_comb begin
      pend_set = '0;
      pend_clr = '0;
      stop_set = 1'b0;
      stop_clr = 1'b0;
      rst_fire = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (PIN_DEST[2*i +: 2] == DEST_PEND) begin
            for (int b = 0; b < PEND_W; b++) begin
               if (PIN_PBIT[PBIT_FW*i +: PBIT_FW] == PBIT_FW'(b)) begin
                  if (act[i])   pend_set[b] = 1'b1;
                  if (deact[i]) pend_clr[b] = 1'b1;
               end
            end
         end else if (PIN_DEST[2*i +: 2] == DEST_STOP) begin
            if (act[i])   stop_set = 1'b1;
            if (deact[i]) stop_clr = 1'b1;
         end else if (PIN_DEST[2*i +: 2] == DEST_RESET) begin
            if (act[i]) rst_fire = 1'b1;
         end
      end
   end

endmodule

// File: rtl/pinc_pend.sv
module pinc_pend #(
   parameter int PEND_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PEND_W-1:0] pend_set,
   input  logic [PEND_W-1:0] pend_clr,
   input  logic [PEND_W-1:0] ack_mask,
   output logic [PEND_W-1:0] pend_q,
   output logic              irq_req
);

   // Clears from the pin or the acknowledge first, then sets on top: set wins.
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~(pend_clr | ack_mask)) | pend_set;
   end

   assign irq_req = |pend_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_set != '0) |=> ((pend_q & $past(pend_set)) == $past(pend_set))); // R9

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_mask & ~pend_set) != '0) |=> ((pend_q & $past(ack_mask & ~pend_set)) == '0)); // R9

   AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_set == '0) |=> ((pend_q & ~$past(pend_q)) == '0)); // R2

endmodule

// File: rtl/pinc_core_ctl.sv
module pinc_core_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_set,
   input  logic stop_clr,
   input  logic rst_fire,
   output logic stop_q,
   output logic rst_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         rst_q  <= 1'b0;
      end else begin
         if (stop_set)      stop_q <= 1'b1;
         else if (stop_clr) stop_q <= 1'b0;
         rst_q <= rst_fire;
      end
   end

   AST_RESET_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q); // R5

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_set && !stop_clr) |=> $stable(stop_q)); // R4

endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner
   import pinc_pkg::*;
#(
   parameter int                    NUM_PINS  = 6,
   parameter int                    PEND_W    = 8,
   // Per pin, pin 0 in the low field: sense code, destination, pending bit.
   parameter logic [2*NUM_PINS-1:0] PIN_SENSE = 12'b00_01_01_10_00_00,
   parameter logic [2*NUM_PINS-1:0] PIN_DEST  = 12'b00_10_01_00_00_00,
   parameter logic [PBIT_FW*NUM_PINS-1:0] PIN_PBIT =
      {8'd3, 8'd0, 8'd0, 8'd2, 8'd1, 8'd0},
   parameter logic [NUM_PINS-1:0]   IDLE_LVL  = 6'b011000,
   localparam int                   IDX_W     = $clog2(NUM_PINS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pin_evt_vld,
   input  logic [IDX_W-1:0]    pin_evt_idx,
   input  logic                pin_evt_lvl,
   input  logic [PEND_W-1:0]   ack_mask,
   output logic [PEND_W-1:0]   pend_vec,
   output logic                irq_req,
   output logic                core_stop,
   output logic                core_reset_req,
   output logic [NUM_PINS-1:0] pin_level
);

   localparam logic [MAX_PINS-1:0] IDLE_REF =
      idle_of((2*MAX_PINS)'(PIN_SENSE), NUM_PINS);

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("pin_conditioner: NUM_PINS out of range");
   end
   if (PEND_W < 1 || PEND_W > 256) begin : g_bad_pend
      $error("pin_conditioner: PEND_W out of range");
   end
   if (IDLE_LVL != IDLE_REF[NUM_PINS-1:0]) begin : g_bad_idle
      $error("pin_conditioner: IDLE_LVL disagrees with PIN_SENSE");
   end

   logic [NUM_PINS-1:0] chg;
   logic [PEND_W-1:0]   pend_set;
   logic [PEND_W-1:0]   pend_clr;
   logic                stop_set;
   logic                stop_clr;
   logic                rst_fire;

   pinc_state #(
      .NUM_PINS (NUM_PINS),
      .IDX_W    (IDX_W),
      .IDLE_LVL (IDLE_LVL)
   ) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_vld (pin_evt_vld),
      .evt_idx (pin_evt_idx),
      .evt_lvl (pin_evt_lvl),
      .lvl_q   (pin_level),
      .chg     (chg)
   );

   pinc_decode #(
      .NUM_PINS  (NUM_PINS),
      .PEND_W    (PEND_W),
      .PIN_SENSE (PIN_SENSE),
      .PIN_DEST  (PIN_DEST),
      .PIN_PBIT  (PIN_PBIT)
   ) u_decode (
      .chg      (chg),
      .new_lvl  (pin_evt_lvl),
      .pend_set (pend_set),
      .pend_clr (pend_clr),
      .stop_set (stop_set),
      .stop_clr (stop_clr),
      .rst_fire (rst_fire)
   );

   pinc_pend #(
      .PEND_W (PEND_W)
   ) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_set (pend_set),
      .pend_clr (pend_clr),
      .ack_mask (ack_mask),
      .pend_q   (pend_vec),
      .irq_req  (irq_req)
   );

   pinc_core_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_set (stop_set),
      .stop_clr (stop_clr),
      .rst_fire (rst_fire),
      .stop_q   (core_stop),
      .rst_q    (core_reset_req)
   );

   AST_REQ_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_evt_vld && ((pend_vec & ~ack_mask) == '0)) |=> !irq_req); // R7

endmodule

// File: tb/pin_conditioner_bench.sv
module pin_conditioner_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_evt_vld = 1'b0;
   logic [2:0] pin_evt_idx = '0;
   logic       pin_evt_lvl = 1'b0;
   logic [7:0] ack_mask = '0;
   logic [7:0] pend_vec;
   logic       irq_req;
   logic       core_stop;
   logic       core_reset_req;
   logic [5:0] pin_level;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5ns clk = ~clk;

   pin_conditioner u_pin_conditioner (
      .clk            (clk),
      .rst_n          (rst_n),
      .pin_evt_vld    (pin_evt_vld),
      .pin_evt_idx    (pin_evt_idx),
      .pin_evt_lvl    (pin_evt_lvl),
      .ack_mask       (ack_mask),
      .pend_vec       (pend_vec),
      .irq_req        (irq_req),
      .core_stop      (core_stop),
      .core_reset_req (core_reset_req),
      .pin_level      (pin_level)
   );

   // vld | idx | lvl | ack | exp pend | exp stop | exp rst | exp levels | req
   localparam int NV = 24;
   localparam logic [32:0] VEC [NV] = '{
      {1'b1, 3'd0, 1'b1, 8'h00, 8'h01, 1'b0, 1'b0, 6'b011001, 4'd2},  // R2 ext rises
      {1'b1, 3'd0, 1'b1, 8'h00, 8'h01, 1'b0, 1'b0, 6'b011001, 4'd1},  // R1 repeat
      {1'b1, 3'd1, 1'b1, 8'h00, 8'h03, 1'b0, 1'b0, 6'b011011, 4'd2},  // R2 mgmt rises
      {1'b1, 3'd0, 1'b0, 8'h00, 8'h02, 1'b0, 1'b0, 6'b011010, 4'd2},  // R2 ext falls
      {1'b1, 3'd2, 1'b1, 8'h00, 8'h02, 1'b0, 1'b0, 6'b011110, 4'd3},  // R3 rise ignored
      {1'b1, 3'd2, 1'b0, 8'h00, 8'h06, 1'b0, 1'b0, 6'b011010, 4'd3},  // R3 fall sets
      {1'b1, 3'd2, 1'b1, 8'h00, 8'h06, 1'b0, 1'b0, 6'b011110, 4'd3},  // R3 bit kept
      {1'b1, 3'd3, 1'b0, 8'h00, 8'h06, 1'b1, 1'b0, 6'b010110, 4'd4},  // R4 stop
      {1'b1, 3'd3, 1'b0, 8'h00, 8'h06, 1'b1, 1'b0, 6'b010110, 4'd1},  // R1 repeat
      {1'b1, 3'd3, 1'b1, 8'h00, 8'h06, 1'b0, 1'b0, 6'b011110, 4'd4},  // R4 release
      {1'b1, 3'd4, 1'b0, 8'h00, 8'h06, 1'b0, 1'b1, 6'b001110, 4'd5},  // R5 pulse
      {1'b0, 3'd0, 1'b0, 8'h00, 8'h06, 1'b0, 1'b0, 6'b001110, 4'd5},  // R5 one cycle
      {1'b1, 3'd4, 1'b0, 8'h00, 8'h06, 1'b0, 1'b0, 6'b001110, 4'd1},  // R1 no repulse
      {1'b1, 3'd4, 1'b1, 8'h00, 8'h06, 1'b0, 1'b0, 6'b011110, 4'd5},  // R5 rise silent
      {1'b1, 3'd5, 1'b1, 8'h00, 8'h0E, 1'b0, 1'b0, 6'b111110, 4'd6},  // R6 soft set
      {1'b1, 3'd6, 1'b0, 8'h00, 8'h0E, 1'b0, 1'b0, 6'b111110, 4'd8},  // R8 index 6
      {1'b1, 3'd7, 1'b1, 8'h00, 8'h0E, 1'b0, 1'b0, 6'b111110, 4'd8},  // R8 index 7
      {1'b0, 3'd0, 1'b0, 8'h04, 8'h0A, 1'b0, 1'b0, 6'b111110, 4'd9},  // R9 ack bit 2
      {1'b0, 3'd0, 1'b0, 8'h02, 8'h08, 1'b0, 1'b0, 6'b111110, 4'd9},  // R9 ack bit 1
      {1'b1, 3'd5, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 6'b011110, 4'd6},  // R6 soft clear
      {1'b1, 3'd1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 6'b011100, 4'd2},  // R2 mgmt falls
      {1'b1, 3'd1, 1'b1, 8'h02, 8'h02, 1'b0, 1'b0, 6'b011110, 4'd9},  // R9 set wins
      {1'b0, 3'd0, 1'b0, 8'h02, 8'h00, 1'b0, 1'b0, 6'b011110, 4'd9},  // R9 cleared
      {1'b1, 3'd2, 1'b0, 8'hFF, 8'h04, 1'b0, 1'b0, 6'b011010, 4'd9}   // R9 set wins
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] i, input logic l, input logic [7:0] a);
      pin_evt_vld = v;
      pin_evt_idx = i;
      pin_evt_lvl = l;
      ack_mask    = a;
   endtask

   task automatic check_state(input string req, input logic [7:0] ep, input logic es,
                              input logic er, input logic [5:0] el);
      logic [15:0] got;
      logic [15:0] exp;
      got = {pend_vec, core_stop, core_reset_req, pin_level};
      exp = {ep, es, er, el};
      check(got === exp, req, 32'(got), 32'(exp));
      check(irq_req === (ep != 8'h00), "R7", 32'(irq_req), 32'(ep != 8'h00));
   endtask

   initial begin
      #(200000 * 10ns);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      drive(1'b0, 3'd0, 1'b0, 8'h00);
      repeat (3) @(negedge clk);
      // R10 reset state
      check_state("R10", 8'h00, 1'b0, 1'b0, 6'b011000);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         drive(VEC[k][32], VEC[k][31:29], VEC[k][28], VEC[k][27:20]);
         @(negedge clk);
         check_state($sformatf("R%0d", VEC[k][3:0]), VEC[k][19:12], VEC[k][11],
                     VEC[k][10], VEC[k][9:4]);
      end

      // Mid-run reset with stop asserted and pending bits set: R10
      drive(1'b1, 3'd3, 1'b0, 8'h00);
      @(negedge clk);
      check_state("R4", 8'h04, 1'b1, 1'b0, 6'b010010);
      drive(1'b0, 3'd0, 1'b0, 8'h00);
      rst_n = 1'b0;
      @(negedge clk);
      check_state("R10", 8'h00, 1'b0, 1'b0, 6'b011000);
      rst_n = 1'b1;

      // Idle levels repeated right after reset give no stop and no reset: R10
      drive(1'b1, 3'd4, 1'b1, 8'h00);
      @(negedge clk);
      check_state("R10", 8'h00, 1'b0, 1'b0, 6'b011000);
      drive(1'b1, 3'd3, 1'b1, 8'h00);
      @(negedge clk);
      check_state("R10", 8'h00, 1'b0, 1'b0, 6'b011000);
      drive(1'b0, 3'd0, 1'b0, 8'h00);
      @(negedge clk);
      check_state("R10", 8'h00, 1'b0, 1'b0, 6'b011000);

      finish_run();
   end

endmodule